// File: doc/BRIEF.md
# Programmable DRAM Command Sequencer

This block replays a short program of DRAM command words. The program is held in an array of 32 slots, and each slot is a pair of 64-bit words. The command word is the payload sent toward the memory. Its low bits carry a chip-select field and a two-bit clock-enable field. The control word says how long to wait after the command, how often that wait repeats, which slot comes next, and whether the slot ends the program.

Software loads the slots and the configuration through a simple write port, writes a start bit, and then watches a 64-bit status word. Read-data comparison, ECC and calibration live outside the block, and each reports its failure as a single input flag. Every run drives exactly one target port, chosen beforehand. A program ends on a slot carrying the end marker. That slot is issued as a deselect, and its own delay is never applied, so a program relies on it to make the previous slot's delay take effect.

Top module: `cmdseq_engine`

## Requirements
- R1: After reset, status_o is zero, cs_n_o is 4'hF, cke_o is 0 and no bit of cmd_valid_o is set.
- R2: Writes to address k (0..31) load the command word of slot k, and writes to address 32+k load its control word. A run begins at slot 0 one clock after the start write. It follows the next-slot field (control bits [28:24]), and each issued slot's command word appears on cmd_o for one cycle, flagged by cmd_valid_o.
- R3: A non-final slot with delay d (control bits [15:0]) and repeat r (control bits [23:16]) is followed by the next issue exactly d*(r+1)+1 clocks later.
- R4: A slot with the end marker (control bit 32) is issued with cs_n_o = 4'hF and with cke_o unchanged from the previous command. Its delay is skipped, and status_o shows done alone (64'h4000_0000_0000_0000) from that same clock on.
- R5: The status layout is bit 63 busy, bit 62 done, bit 61 hung, bit 60 read miscompare, bit 59 uncorrectable error, bit 58 calibration timeout. All other bits read 0.
- R6: Writing bit 1 of the control register (address 64) while running returns the engine to idle with busy and done both 0. No further command is issued.
- R7: A non-zero fail_i while running (bit 2 miscompare, bit 1 uncorrectable, bit 0 calibration timeout) ends the run on the next clock. Done is set together with the matching failure bits, cs_n_o reads 4'hF, and no further command is issued. fail_i has no effect while idle.
- R8: With a non-zero limit L written to address 66, a run still busy L+1 clocks after its start write is stopped, and status_o becomes hung alone (64'h2000_0000_0000_0000). A limit of 0 disables the watchdog.
- R9: The port register (address 65) chooses which single bit of cmd_valid_o pulses for every issued command.
- R10: With bit 0 of address 67 clear, cs_n_o equals command bits [3:0]. With it set, command bit 2 = 1 deselects (4'hF); otherwise exactly one select goes low, at the index given by command bits [1:0].
- R11: Writing bit 0 of the control register while idle clears every status bit and sets busy. The same write while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register/array write strobe |
| wr_addr | input | 7 | Write address (slots, control words, configuration) |
| wr_data | input | 64 | Write data |
| fail_i | input | 3 | Failure flags from the datapath |
| cmd_o | output | 64 | Command word of the slot being issued |
| cs_n_o | output | 4 | Active-low chip selects |
| cke_o | output | 2 | Clock enable |
| cmd_valid_o | output | 4 | One-hot per-port command strobe |
| status_o | output | 64 | Busy, done, hung and failure class |

## Verification
The bench aims at the exact spacing of issues across delay-with-repeat waits and zero-delay hops. A counter that is off by one on reload, or that ignores the repeat count, shifts the predicted issue cycle, and the scoreboard reports it. The final slot is a second target. A design that applied its delay would raise done late, and one that sent its command word raw would leak chip selects or toggle CKE. Stop, fail abort and the watchdog are each timed to the clock. A design that kept running after any of them would produce an unexpected issue or a wrong status word. Encoded chip selects are also checked, because a shift in the wrong direction would select the wrong rank.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int STAT_W    = 64;
  localparam int ST_BUSY   = 63;
  localparam int ST_DONE   = 62;
  localparam int ST_HUNG   = 61;
  localparam int ST_FAIL_L = 58;
  localparam int FAIL_W    = 3;

  localparam int CS_W      = 4;
  localparam int CKE_LSB   = 4;
  localparam int CKE_W     = 2;

  localparam int DLY_LSB   = 0;
  localparam int DLY_W     = 16;
  localparam int RPT_LSB   = 16;
  localparam int RPT_W     = 8;
  localparam int NXT_LSB   = 24;
  localparam int END_BIT   = 32;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cmdseq_array.sv
module cmdseq_array #(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 64,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              wr_cmd_en,
  input  logic              wr_ctl_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_cmd,
  output logic [WORD_W-1:0] rd_ctl
);
  logic [WORD_W-1:0] cmd_mem [SLOTS];
  logic [WORD_W-1:0] ctl_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_cmd_en) cmd_mem[wr_idx] <= wr_data;
    if (wr_ctl_en) ctl_mem[wr_idx] <= wr_data;
  end

  assign rd_cmd = cmd_mem[rd_idx];
  assign rd_ctl = ctl_mem[rd_idx];
endmodule

// File: rtl/cmdseq_wait.sv
module cmdseq_wait
  import cmdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [RPT_W-1:0] rpt_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [DLY_W-1:0] dly_q, dly_d, rl_q, rl_d;
  logic [RPT_W-1:0] rpt_q, rpt_d;

  always_comb begin
    dly_d = dly_q;
    rpt_d = rpt_q;
    rl_d  = rl_q;
    if (load_i) begin
      dly_d = dly_i;
      rpt_d = rpt_i;
      rl_d  = dly_i;
    end else if (run_i) begin
      if (dly_q == DLY_W'(1)) begin
        if (rpt_q != '0) begin
          rpt_d = rpt_q - RPT_W'(1);
          dly_d = rl_q;
        end
      end else begin
        dly_d = dly_q - DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      rpt_q <= '0;
      rl_q  <= '0;
    end else if (load_i || run_i) begin
      dly_q <= dly_d;
      rpt_q <= rpt_d;
      rl_q  <= rl_d;
    end
  end

  assign last_o = (dly_q == DLY_W'(1)) && (rpt_q == '0);

  AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (dly_q != '0)); // R3
endmodule

// File: rtl/cmdseq_cs_map.sv
module cmdseq_cs_map
  import cmdseq_pkg::*;
(
  input  logic            quad_i,
  input  logic [CS_W-1:0] field_i,
  output logic [CS_W-1:0] cs_n_o
);
  always_comb begin
    if (!quad_i)         cs_n_o = field_i;
    else if (field_i[2]) cs_n_o = '1;
    else                 cs_n_o = ~(CS_W'(1) << field_i[1:0]);
  end
endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
  import cmdseq_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int WORD_W = 64,
  parameter int NPORTS = 4,
  parameter int WD_W   = 32,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int PORT_W = $clog2(NPORTS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [FAIL_W-1:0] fail_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic [CS_W-1:0]   cs_n_o,
  output logic [CKE_W-1:0]  cke_o,
  output logic [NPORTS-1:0] cmd_valid_o,
  output logic [STAT_W-1:0] status_o
);
  // address decode
  logic sel_cmd, sel_ctl, sel_reg;
  logic reg_ctrl, reg_port, reg_wd, reg_quad;
  logic ctrl_start, ctrl_stop;

  assign sel_cmd  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == 2'b00);
  assign sel_ctl  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == 2'b01);
  assign sel_reg  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == 2'b10);
  assign reg_ctrl = sel_reg && (wr_addr[IDX_W-1:0] == IDX_W'(0));
  assign reg_port = sel_reg && (wr_addr[IDX_W-1:0] == IDX_W'(1));
  assign reg_wd   = sel_reg && (wr_addr[IDX_W-1:0] == IDX_W'(2));
  assign reg_quad = sel_reg && (wr_addr[IDX_W-1:0] == IDX_W'(3));
  assign ctrl_start = reg_ctrl && wr_data[0];
  assign ctrl_stop  = reg_ctrl && wr_data[1];

  // state
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  pc_q, pc_d;
  logic              busy_q, busy_d, done_q, done_d, hung_q, hung_d;
  logic [FAIL_W-1:0] fail_q, fail_d;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic [CKE_W-1:0]  cke_q, cke_d;
  logic [NPORTS-1:0] vld_q, vld_d;
  logic [PORT_W-1:0] port_q;
  logic              quad_q;
  logic [WD_W-1:0]   wd_lim_q, wd_cnt_q, wd_cnt_d;

  logic [WORD_W-1:0] slot_cmd, slot_ctl;
  logic [CS_W-1:0]   mapped_cs;
  logic              wait_load, wait_last;
  logic [DLY_W-1:0]  slot_dly;
  logic [RPT_W-1:0]  slot_rpt;
  logic [IDX_W-1:0]  slot_nxt;
  logic              slot_end;
  logic              wd_expire;

  cmdseq_array #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_array (
    .clk       (clk),
    .wr_cmd_en (sel_cmd),
    .wr_ctl_en (sel_ctl),
    .wr_idx    (wr_addr[IDX_W-1:0]),
    .wr_data   (wr_data),
    .rd_idx    (pc_q),
    .rd_cmd    (slot_cmd),
    .rd_ctl    (slot_ctl)
  );

  assign slot_dly = slot_ctl[DLY_LSB +: DLY_W];
  assign slot_rpt = slot_ctl[RPT_LSB +: RPT_W];
  assign slot_nxt = slot_ctl[NXT_LSB +: IDX_W];
  assign slot_end = slot_ctl[END_BIT];

  logic unused_ctl;
  assign unused_ctl = ^{slot_ctl[WORD_W-1:END_BIT+1], slot_ctl[END_BIT-1:NXT_LSB+IDX_W]};

  cmdseq_cs_map u_csmap (
    .quad_i  (quad_q),
    .field_i (slot_cmd[CS_W-1:0]),
    .cs_n_o  (mapped_cs)
  );

  cmdseq_wait u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wait_load),
    .dly_i  (slot_dly),
    .rpt_i  (slot_rpt),
    .run_i  (state_q == S_WAIT),
    .last_o (wait_last)
  );

  assign wd_expire = busy_q && (wd_lim_q != '0) && (wd_cnt_q == wd_lim_q);

  // next state
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    busy_d    = busy_q;
    done_d    = done_q;
    hung_d    = hung_q;
    fail_d    = fail_q;
    cmd_d     = cmd_q;
    cs_d      = '1;
    cke_d     = cke_q;
    vld_d     = '0;
    wait_load = 1'b0;
    wd_cnt_d  = busy_q ? wd_cnt_q + WD_W'(1) : wd_cnt_q;

    if (busy_q && ctrl_stop) begin
      state_d = S_IDLE;
      busy_d  = 1'b0;
    end else if (busy_q && (fail_i != '0)) begin
      state_d = S_IDLE;
      busy_d  = 1'b0;
      done_d  = 1'b1;
      fail_d  = fail_i;
    end else if (wd_expire) begin
      state_d = S_IDLE;
      busy_d  = 1'b0;
      hung_d  = 1'b1;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (ctrl_start) begin
            state_d  = S_ISSUE;
            pc_d     = '0;
            busy_d   = 1'b1;
            done_d   = 1'b0;
            hung_d   = 1'b0;
            fail_d   = '0;
            wd_cnt_d = '0;
          end
        end
        S_ISSUE: begin
          vld_d         = '0;
          vld_d[port_q] = 1'b1;
          cmd_d         = slot_cmd;
          if (slot_end) begin
            state_d = S_IDLE;
            busy_d  = 1'b0;
            done_d  = 1'b1;
          end else begin
            cs_d  = mapped_cs;
            cke_d = slot_cmd[CKE_LSB +: CKE_W];
            pc_d  = slot_nxt;
            if (slot_dly == '0) begin
              state_d = S_ISSUE;
            end else begin
              state_d   = S_WAIT;
              wait_load = 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (wait_last) state_d = S_ISSUE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      pc_q     <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      hung_q   <= 1'b0;
      fail_q   <= '0;
      cmd_q    <= '0;
      cs_q     <= '1;
      cke_q    <= '0;
      vld_q    <= '0;
      wd_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
      hung_q   <= hung_d;
      fail_q   <= fail_d;
      cmd_q    <= cmd_d;
      cs_q     <= cs_d;
      cke_q    <= cke_d;
      vld_q    <= vld_d;
      wd_cnt_q <= wd_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q   <= '0;
      quad_q   <= 1'b0;
      wd_lim_q <= '0;
    end else begin
      if (reg_port) port_q   <= wr_data[PORT_W-1:0];
      if (reg_quad) quad_q   <= wr_data[0];
      if (reg_wd)   wd_lim_q <= wr_data[WD_W-1:0];
    end
  end

  assign cmd_o       = cmd_q;
  assign cs_n_o      = cs_q;
  assign cke_o       = cke_q;
  assign cmd_valid_o = vld_q;
  always_comb begin
    status_o = '0;
    status_o[ST_BUSY] = busy_q;
    status_o[ST_DONE] = done_q;
    status_o[ST_HUNG] = hung_q;
    status_o[ST_FAIL_L +: FAIL_W] = fail_q;
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_valid_o)); // R9
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o == '0) |-> (cs_n_o == '1)); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_DONE] |-> !status_o[ST_BUSY]); // R5
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_FAIL_L +: FAIL_W] != '0) |-> status_o[ST_DONE]); // R7
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctrl_stop) |=> (!status_o[ST_BUSY] && !status_o[ST_DONE])); // R6
  AST_HUNG_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_HUNG] |-> !status_o[ST_BUSY]); // R8
  AST_QUAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_valid_o != '0) && quad_q && $stable(quad_q)) |-> ($countones(~cs_n_o) <= 1)); // R10
endmodule

// File: tb/cmdseq_engine_test.sv
module cmdseq_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  fail_i = '0;
  logic [63:0] cmd_o;
  logic [3:0]  cs_n_o;
  logic [1:0]  cke_o;
  logic [3:0]  cmd_valid_o;
  logic [63:0] status_o;

  cmdseq_engine uut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    int          t;
    logic [3:0]  cs;
    logic [1:0]  cke;
    logic [63:0] word;
    logic [3:0]  vld;
  } exp_t;
  exp_t sb[$];

  logic [63:0] b0 [32];
  logic [63:0] b1 [32];
  int   bport = 0;
  logic bquad = 1'b0;
  logic [1:0] ecke = 2'b00;

  localparam logic [63:0] ST_BUSY = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ST_DONE = 64'h4000_0000_0000_0000;
  localparam logic [63:0] ST_HUNG = 64'h2000_0000_0000_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [3:0] csmap(input logic [63:0] w, input logic q);
    if (!q)   return w[3:0];
    if (w[2]) return 4'hF;
    return ~(4'b0001 << w[1:0]);
  endfunction

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ld(input int k, input logic [63:0] w0, input logic [63:0] w1);
    b0[k] = w0; b1[k] = w1;
    wr(7'(k), w0);
    wr(7'(32 + k), w1);
  endtask

  function automatic logic [63:0] ctl(input int d, input int r, input int nxt, input bit last);
    return (64'(last) << 32) | (64'(nxt) << 24) | (64'(r) << 16) | 64'(d);
  endfunction

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver: start and push the predicted issues
  task automatic start_and_expect(input int maxn, output int tend);
    int t;
    int idx;
    exp_t e;
    wr(7'd64, 64'd1);
    t = cyc + 1;
    idx = 0;
    tend = -1;
    for (int n = 0; n < maxn; n++) begin
      e.t = t; e.word = b0[idx]; e.vld = 4'(1) << bport;
      if (b1[idx][32]) begin
        e.cs = 4'hF; e.cke = ecke;
        sb.push_back(e);
        tend = t;
        break;
      end
      e.cs = csmap(b0[idx], bquad); e.cke = b0[idx][5:4];
      ecke = b0[idx][5:4];
      sb.push_back(e);
      t += int'(b1[idx][15:0]) * (int'(b1[idx][23:16]) + 1) + 1;
      idx = int'(b1[idx][28:24]);
    end
  endtask

  // monitor: pop and compare every issue
  always @(negedge clk) begin
    if (rst_n && cmd_valid_o != 4'b0) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6/R7 unexpected issue", {60'b0, cmd_valid_o}, 64'b0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.t, "R3 issue cycle", 64'(cyc), 64'(e.t));
        chk(cmd_o == e.word, "R2 command word", cmd_o, e.word);
        chk(cs_n_o == e.cs, "R4/R10 chip selects", {60'b0, cs_n_o}, {60'b0, e.cs});
        chk(cke_o == e.cke, "R4 cke", {62'b0, cke_o}, {62'b0, e.cke});
        chk(cmd_valid_o == e.vld, "R9 port strobe", {60'b0, cmd_valid_o}, {60'b0, e.vld});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int tend;
    int ts;
    for (int k = 0; k < 32; k++) begin b0[k] = '0; b1[k] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status_o == 64'b0, "R1 status", status_o, 64'b0);
    chk(cs_n_o == 4'hF, "R1 cs_n", {60'b0, cs_n_o}, 64'hF);
    chk(cke_o == 2'b0 && cmd_valid_o == 4'b0, "R1 cke/valid", {58'b0, cke_o, cmd_valid_o}, 64'b0);
    rst_n = 1'b1;

    // R2 R3 R4: dual mode, port 1, chained slots with repeats
    bport = 1; bquad = 1'b0;
    wr(7'd65, 64'd1);
    ld(0, 64'hABCD_0000_0000_003E, ctl(3, 1, 5, 0));
    ld(5, 64'h0000_1111_0000_001D, ctl(0, 0, 7, 0));
    ld(7, 64'h0000_0000_2222_002B, ctl(2, 2, 2, 0));
    ld(2, 64'h0000_0000_0000_0030, ctl(50, 0, 0, 1));
    start_and_expect(10, tend);
    wait_until(tend - 1);
    chk(status_o == ST_BUSY, "R4 busy before final slot", status_o, ST_BUSY);
    wait_until(tend);
    chk(status_o == ST_DONE, "R4 done alone at final slot", status_o, ST_DONE);
    wait_until(tend + 60);
    chk(sb.size() == 0, "R2 all issues seen", 64'(sb.size()), 64'b0);

    // R10 quad mode on port 3
    bport = 3; bquad = 1'b1;
    wr(7'd65, 64'd3);
    wr(7'd67, 64'd1);
    ld(0, 64'h0000_0000_0000_0012, ctl(1, 0, 1, 0));
    ld(1, 64'h0000_0000_0000_0014, ctl(0, 0, 3, 0));
    ld(3, 64'h0000_0000_0000_000B, ctl(4, 1, 4, 0));
    ld(4, 64'h0000_0000_0000_00FF, ctl(0, 0, 0, 1));
    start_and_expect(10, tend);
    wait_until(tend + 3);
    chk(status_o == ST_DONE, "R10 quad run done", status_o, ST_DONE);
    chk(sb.size() == 0, "R10 quad issues seen", 64'(sb.size()), 64'b0);

    // R6 stop while running
    bport = 0; bquad = 1'b0;
    wr(7'd67, 64'd0);
    wr(7'd65, 64'd0);
    ld(0, 64'h0000_0000_0000_003E, ctl(1000, 0, 1, 0));
    ld(1, 64'h0000_0000_0000_0000, ctl(0, 0, 0, 1));
    start_and_expect(1, tend);
    ts = cyc;
    chk(status_o == ST_BUSY, "R11 start sets busy only", status_o, ST_BUSY);
    wr(7'd64, 64'd1);
    chk(sb.size() == 0 || cyc <= ts + 1, "R11 restart ignored", 64'(sb.size()), 64'b0);
    wr(7'd64, 64'd2);
    chk(status_o == 64'b0, "R6 stop clears busy and done", status_o, 64'b0);
    wait_until(cyc + 1100);
    chk(cs_n_o == 4'hF, "R6 deselected after stop", {60'b0, cs_n_o}, 64'hF);

    // R7 fail abort
    start_and_expect(1, tend);
    repeat (3) @(negedge clk);
    fail_i = 3'b010;
    @(negedge clk);
    fail_i = 3'b000;
    chk(status_o == 64'h4800_0000_0000_0000, "R7 abort status", status_o, 64'h4800_0000_0000_0000);
    chk(cs_n_o == 4'hF, "R7 deselect after abort", {60'b0, cs_n_o}, 64'hF);
    fail_i = 3'b100;
    @(negedge clk);
    fail_i = 3'b000;
    @(negedge clk);
    chk(status_o == 64'h4800_0000_0000_0000, "R7 fail ignored while idle", status_o, 64'h4800_0000_0000_0000);

    // R8 watchdog
    wr(7'd66, 64'd10);
    start_and_expect(1, tend);
    ts = cyc;
    chk(status_o == ST_BUSY, "R11 start clears failure bits", status_o, ST_BUSY);
    wait_until(ts + 10);
    chk(status_o == ST_BUSY, "R8 still busy at limit", status_o, ST_BUSY);
    wait_until(ts + 11);
    chk(status_o == ST_HUNG, "R8 hung alone", status_o, ST_HUNG);
    wait_until(ts + 1100);
    chk(status_o == ST_HUNG, "R8 stays stopped", status_o, ST_HUNG);
    chk(sb.size() == 0, "R8 issues seen", 64'(sb.size()), 64'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule